// File: doc/BRIEF.md
# Ring-Tagged Multi-Way Translation Buffer

This block translates 32-bit virtual addresses to physical addresses through five ways of cached page mappings. Ways 0 to 3 hold 4 KiB pages and serve as refill ways. Way 4 holds large pages whose size comes from a 2-bit configuration input. Each entry stores a virtual page tag, a physical page, an 8-bit address-space identifier (ASID) and a 4-bit attribute.

An ASID is turned into a privilege ring by searching a 32-bit ring-identity register. That register packs one ASID byte per ring, with ring 0 in the lowest byte. A lookup names the current ring and an instruction/data side. One cycle later the block returns the physical address, or it returns a cause code for a miss, a multi-way hit or a privilege violation.

Entries are loaded from a page-table-entry word. The write names its way directly, or it asks for automatic placement, which rotates over the refill ways.

Top module: `tlb_asid_ring`

## Requirements
- R1: After reset, `rid_q` reads 0x04030201, `rs_valid` and `wr_err` are 0, and every lookup misses because all entries hold ASID 0.
- R2: A ring-identity write stores `rid_wdata[31:8]` and forces the low byte (ring 0) to 0x01.
- R3: A lookup presented with `lk_valid` produces `rs_valid` on the next cycle only. On success, `rs_paddr` is the entry's physical page OR'd with the address bits below the way's page mask, and `rs_cause` is 0.
- R4: Refill ways 0 to 3 use 4 KiB pages. With 16 refill entries in total (4 per way), the entry index is address bits 13:12, and the tag is bits 31:12.
- R5: Way 4 uses page mask 0xFFF00000 shifted left by 2×`w4_size`. Its entry index is the two address bits just above that mask's page offset.
- R6: A written entry takes its ASID from the ring-identity byte selected by PTE bits 5:4, and its attribute from PTE bits 3:0. A hit reports the lowest ring whose ring-identity byte equals the entry ASID. An entry with ASID 0, or with an ASID found in no byte, never hits.
- R7: When no way hits, the cause is 16 on the instruction side (`lk_data`=0) or 24 on the data side.
- R8: When more than one way hits, the cause is 17 on the instruction side or 25 on the data side.
- R9: A single hit whose ring is numerically lower than `lk_ring` gives cause 18 (instruction) or 26 (data). It still reports the way, entry, ring and attribute, with `rs_paddr` equal to 0.
- R10: An automatic write increments a 2-bit round-robin counter and then uses the new value as the way. The counter is 0 at reset, so the first automatic write goes to way 1.
- R11: A direct write to a way numbered 5 or above, or to a way marked fixed by `WAY_FIXED`, changes no entry and raises `wr_err` for one cycle. Every other write leaves `wr_err` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w4_size | input | 2 | Page-size code for way 4 |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Virtual address to translate |
| lk_data | input | 1 | 1 = data side, 0 = instruction side |
| lk_ring | input | 2 | Current privilege ring |
| wr_en | input | 1 | Entry write strobe |
| wr_auto | input | 1 | Use round-robin way placement |
| wr_way | input | 3 | Target way for a direct write |
| wr_vaddr | input | 32 | Virtual address of the entry written |
| wr_pte | input | 32 | Page-table-entry word |
| rid_we | input | 1 | Ring-identity register write |
| rid_wdata | input | 32 | New ring-identity value |
| rid_q | output | 32 | Ring-identity register |
| wr_err | output | 1 | Rejected write, one cycle after the write |
| rs_valid | output | 1 | Lookup result strobe |
| rs_cause | output | 6 | 0, or a cause code as in R7 to R9 |
| rs_way | output | 3 | Hit way |
| rs_entry | output | 3 | Hit entry index |
| rs_ring | output | 2 | Ring of the hit entry |
| rs_paddr | output | 32 | Physical address |
| rs_attr | output | 4 | Attribute of the hit entry |

## Verification
The checks on page offsets assume that every configured page is at least 4 KiB, which holds for both way kinds. They also assume that `lk_ring` and `lk_addr` are sampled in the request cycle, so the stimulus holds them steady across the edge. The automatic-write error property assumes that no refill way is fixed, which matches the default configuration used by the bench. The bench changes `w4_size` only when no way-4 lookup is in flight, so each result is judged against one page size.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [5:0] {
    C_NONE    = 6'd0,
    C_I_MISS  = 6'd16,
    C_I_MULTI = 6'd17,
    C_I_PRIV  = 6'd18,
    C_D_MISS  = 6'd24,
    C_D_MULTI = 6'd25,
    C_D_PRIV  = 6'd26
  } cause_e;
endpackage

// File: rtl/tlb_ring_map.sv
module tlb_ring_map (
  input  logic [31:0] rid,
  input  logic [7:0]  asid,
  output logic        found,
  output logic [1:0]  ring
);
  // Search from ring 3 down so the lowest matching ring wins.
  always_comb begin
    found = 1'b0;
    ring  = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (rid[i*8 +: 8] == asid) begin
        found = 1'b1;
        ring  = 2'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int ENTRIES  = 4,
  parameter bit VARIABLE = 1'b0,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  size,
  input  logic [31:0] lk_addr,
  input  logic        wr_en,
  input  logic [31:0] wr_vaddr,
  input  logic [31:0] wr_pte,
  input  logic [7:0]  wr_asid,
  output logic        lk_match,
  output logic [7:0]  lk_asid,
  output logic [31:0] lk_ppn,
  output logic [3:0]  lk_attr,
  output logic [2:0]  lk_idx,
  output logic [31:0] page_mask
);
  logic [31:0] tag_m  [ENTRIES];
  logic [31:0] ppn_m  [ENTRIES];
  logic [3:0]  attr_m [ENTRIES];
  logic [7:0]  asid_m [ENTRIES];
  logic [4:0]  base;
  logic [IDX_W-1:0] ridx, widx;

  always_comb begin
    page_mask = VARIABLE ? (32'hFFF0_0000 << {size, 1'b0}) : 32'hFFFF_F000;
    base      = VARIABLE ? (5'd20 + {2'b00, size, 1'b0}) : 5'd12;
    ridx      = IDX_W'(lk_addr >> base);
    widx      = IDX_W'(wr_vaddr >> base);
  end

  // Tag, page and attribute storage carry no reset (RAM-friendly).
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[widx]  <= wr_vaddr & page_mask;
      ppn_m[widx]  <= wr_pte & page_mask;
      attr_m[widx] <= wr_pte[3:0];
    end
  end

  // ASID 0 marks an empty entry, so only this array is reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) asid_m[i] <= 8'd0;
    end else if (wr_en) begin
      asid_m[widx] <= wr_asid;
    end
  end

  always_comb begin
    lk_asid  = asid_m[ridx];
    lk_ppn   = ppn_m[ridx];
    lk_attr  = attr_m[ridx];
    lk_idx   = 3'(ridx);
    lk_match = (lk_asid != 8'd0) && (tag_m[ridx] == (lk_addr & page_mask));
  end
endmodule

// File: rtl/tlb_asid_ring.sv
module tlb_asid_ring #(
  parameter int          REFILL_ENTRIES = 16,
  parameter int          VAR_ENTRIES    = 4,
  parameter logic [4:0]  WAY_FIXED      = 5'b00000,
  parameter logic [31:0] RID_RESET      = 32'h0403_0201
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  w4_size,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic        lk_data,
  input  logic [1:0]  lk_ring,
  input  logic        wr_en,
  input  logic        wr_auto,
  input  logic [2:0]  wr_way,
  input  logic [31:0] wr_vaddr,
  input  logic [31:0] wr_pte,
  input  logic        rid_we,
  input  logic [31:0] rid_wdata,
  output logic [31:0] rid_q,
  output logic        wr_err,
  output logic        rs_valid,
  output logic [5:0]  rs_cause,
  output logic [2:0]  rs_way,
  output logic [2:0]  rs_entry,
  output logic [1:0]  rs_ring,
  output logic [31:0] rs_paddr,
  output logic [3:0]  rs_attr
);
  import tlb_pkg::*;

  localparam int NUM_REFILL = 4;
  localparam int NUM_WAYS   = NUM_REFILL + 1;
  localparam int RF_PER_WAY = REFILL_ENTRIES / NUM_REFILL;

  logic [31:0] ppn_a  [NUM_WAYS];
  logic [31:0] mask_a [NUM_WAYS];
  logic [7:0]  asid_a [NUM_WAYS];
  logic [3:0]  attr_a [NUM_WAYS];
  logic [2:0]  idx_a  [NUM_WAYS];
  logic [1:0]  ring_a [NUM_WAYS];
  logic [NUM_WAYS-1:0] match_a, found_a, hit_a, wen_a;

  logic [1:0]  rr_q;
  logic [2:0]  tgt;
  logic        wr_ok;
  logic [7:0]  wr_asid;
  logic [31:0] rid_next;

  // Write target and ASID selection
  always_comb begin
    tgt   = wr_auto ? {1'b0, rr_q + 2'd1} : wr_way;
    wr_ok = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (tgt == 3'(w) && !WAY_FIXED[w]) wr_ok = 1'b1;
    wr_asid  = rid_q[{wr_pte[5:4], 3'b000} +: 8];
    rid_next = rid_wdata;
    rid_next[7:0] = 8'h01;
  end

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign wen_a[w] = wr_en && wr_ok && (tgt == 3'(w));
      tlb_way #(
        .ENTRIES (w < NUM_REFILL ? RF_PER_WAY : VAR_ENTRIES),
        .VARIABLE(w >= NUM_REFILL)
      ) u_way (
        .clk      (clk),
        .rst      (rst),
        .size     (w4_size),
        .lk_addr  (lk_addr),
        .wr_en    (wen_a[w]),
        .wr_vaddr (wr_vaddr),
        .wr_pte   (wr_pte),
        .wr_asid  (wr_asid),
        .lk_match (match_a[w]),
        .lk_asid  (asid_a[w]),
        .lk_ppn   (ppn_a[w]),
        .lk_attr  (attr_a[w]),
        .lk_idx   (idx_a[w]),
        .page_mask(mask_a[w])
      );
      tlb_ring_map u_ring (
        .rid  (rid_q),
        .asid (asid_a[w]),
        .found(found_a[w]),
        .ring (ring_a[w])
      );
      assign hit_a[w] = match_a[w] && found_a[w];
    end
  endgenerate

  // Hit resolution
  int unsigned sel;
  cause_e      cause_c;
  logic [31:0] paddr_c;
  logic        one_hit;

  always_comb begin
    sel = 0;
    for (int w = 0; w < NUM_WAYS; w++) if (hit_a[w]) sel = w;
    one_hit = ($countones(hit_a) == 1);
    paddr_c = 32'd0;
    if (hit_a == '0)
      cause_c = lk_data ? C_D_MISS : C_I_MISS;
    else if (!one_hit)
      cause_c = lk_data ? C_D_MULTI : C_I_MULTI;
    else if (ring_a[sel] < lk_ring)
      cause_c = lk_data ? C_D_PRIV : C_I_PRIV;
    else begin
      cause_c = C_NONE;
      paddr_c = ppn_a[sel] | (lk_addr & ~mask_a[sel]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rid_q    <= RID_RESET;
      rr_q     <= 2'd0;
      wr_err   <= 1'b0;
      rs_valid <= 1'b0;
      rs_cause <= 6'd0;
      rs_way   <= 3'd0;
      rs_entry <= 3'd0;
      rs_ring  <= 2'd0;
      rs_paddr <= 32'd0;
      rs_attr  <= 4'd0;
    end else begin
      if (rid_we) rid_q <= rid_next;
      if (wr_en && wr_auto) rr_q <= rr_q + 2'd1;
      wr_err   <= wr_en && !wr_ok;
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_cause <= cause_c;
        rs_paddr <= paddr_c;
        rs_way   <= one_hit ? 3'(sel) : 3'd0;
        rs_entry <= one_hit ? idx_a[sel] : 3'd0;
        rs_ring  <= one_hit ? ring_a[sel] : 2'd0;
        rs_attr  <= one_hit ? attr_a[sel] : 4'd0;
      end
    end
  end
endmodule

// File: rtl/tlb_asid_ring_chk.sv
module tlb_asid_ring_chk #(
  parameter logic [4:0] FIXED = 5'b00000
) (
  input logic        clk,
  input logic        rst,
  input logic        lk_valid,
  input logic [31:0] lk_addr,
  input logic        lk_data,
  input logic [1:0]  lk_ring,
  input logic        wr_en,
  input logic        wr_auto,
  input logic [2:0]  wr_way,
  input logic        rid_we,
  input logic [31:0] rid_wdata,
  input logic [31:0] rid_q,
  input logic        wr_err,
  input logic        rs_valid,
  input logic [5:0]  rs_cause,
  input logic [1:0]  rs_ring,
  input logic [31:0] rs_paddr
);
  p_ring0_byte_r2: assert property (@(posedge clk) disable iff (rst)
    rid_we |=> (rid_q == {$past(rid_wdata[31:8]), 8'h01}));

  p_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);

  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rs_cause != 6'd0 || rs_paddr[11:0] == $past(lk_addr[11:0])));

  p_data_side_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_data) |=> (rs_cause == 6'd0 || rs_cause[3]));

  p_inst_side_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_data) |=> (rs_cause == 6'd0 || !rs_cause[3]));

  p_priv_r9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rs_cause != 6'd0 || rs_ring >= $past(lk_ring)));

  p_auto_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_auto && FIXED[3:0] == 4'd0) |=> !wr_err);

  p_bad_way_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_auto && wr_way >= 3'd5) |=> wr_err);

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_err);
endmodule

bind tlb_asid_ring tlb_asid_ring_chk #(.FIXED(WAY_FIXED)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .lk_data(lk_data), .lk_ring(lk_ring), .wr_en(wr_en), .wr_auto(wr_auto),
  .wr_way(wr_way), .rid_we(rid_we), .rid_wdata(rid_wdata), .rid_q(rid_q),
  .wr_err(wr_err), .rs_valid(rs_valid), .rs_cause(rs_cause),
  .rs_ring(rs_ring), .rs_paddr(rs_paddr)
);

// File: tb/test_tlb_asid_ring.sv
module test_tlb_asid_ring;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  w4_size = 2'd0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = 32'd0;
  logic        lk_data = 1'b0;
  logic [1:0]  lk_ring = 2'd0;
  logic        wr_en = 1'b0;
  logic        wr_auto = 1'b0;
  logic [2:0]  wr_way = 3'd0;
  logic [31:0] wr_vaddr = 32'd0;
  logic [31:0] wr_pte = 32'd0;
  logic        rid_we = 1'b0;
  logic [31:0] rid_wdata = 32'd0;
  logic [31:0] rid_q;
  logic        wr_err, rs_valid;
  logic [5:0]  rs_cause;
  logic [2:0]  rs_way, rs_entry;
  logic [1:0]  rs_ring;
  logic [31:0] rs_paddr;
  logic [3:0]  rs_attr;

  always #10 clk = ~clk;

  tlb_asid_ring i_tlb_asid_ring (
    .clk(clk), .rst(rst), .w4_size(w4_size), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_data(lk_data), .lk_ring(lk_ring),
    .wr_en(wr_en), .wr_auto(wr_auto), .wr_way(wr_way),
    .wr_vaddr(wr_vaddr), .wr_pte(wr_pte), .rid_we(rid_we),
    .rid_wdata(rid_wdata), .rid_q(rid_q), .wr_err(wr_err),
    .rs_valid(rs_valid), .rs_cause(rs_cause), .rs_way(rs_way),
    .rs_entry(rs_entry), .rs_ring(rs_ring), .rs_paddr(rs_paddr),
    .rs_attr(rs_attr)
  );

  typedef struct {
    bit          full;
    logic [5:0]  cause;
    logic [2:0]  way;
    logic [2:0]  entry;
    logic [1:0]  ring;
    logic [31:0] paddr;
    logic [3:0]  attr;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cycles = 0;

  // Monitor: compare each result against the oldest expectation
  always @(negedge clk) begin
    if (!rst && rs_valid) begin
      checks++;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected result: cause=%0d expected none", rs_cause);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rs_cause !== e.cause ||
            (e.full && (rs_way !== e.way || rs_entry !== e.entry ||
                        rs_ring !== e.ring || rs_paddr !== e.paddr ||
                        rs_attr !== e.attr))) begin
          failures++;
          $display("FAIL %s: cause=%0d way=%0d entry=%0d ring=%0d paddr=%h attr=%h expected cause=%0d way=%0d entry=%0d ring=%0d paddr=%h attr=%h",
                   e.req, rs_cause, rs_way, rs_entry, rs_ring, rs_paddr, rs_attr,
                   e.cause, e.way, e.entry, e.ring, e.paddr, e.attr);
        end
      end
    end
  end

  task automatic lookup(input logic [31:0] a, input bit d, input logic [1:0] r,
                        input bit full, input logic [5:0] c,
                        input logic [2:0] w, input logic [2:0] en,
                        input logic [1:0] er, input logic [31:0] pa,
                        input logic [3:0] at, input string req);
    exp_t e;
    e.full = full; e.cause = c; e.way = w; e.entry = en; e.ring = er;
    e.paddr = pa; e.attr = at; e.req = req;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_data = d; lk_ring = r;
    q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic look_ok(input logic [31:0] a, input bit d, input logic [1:0] r,
                         input logic [2:0] w, input logic [2:0] en,
                         input logic [1:0] er, input logic [31:0] pa,
                         input logic [3:0] at, input string req);
    lookup(a, d, r, 1'b1, 6'd0, w, en, er, pa, at, req);
  endtask

  task automatic look_bad(input logic [31:0] a, input bit d, input logic [5:0] c,
                          input string req);
    lookup(a, d, 2'd0, 1'b0, c, 3'd0, 3'd0, 2'd0, 32'd0, 4'd0, req);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input bit auto_w, input logic [2:0] w,
                       input logic [31:0] va, input logic [31:0] pte,
                       input bit exp_err, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_auto = auto_w; wr_way = w; wr_vaddr = va; wr_pte = pte;
    @(negedge clk);
    wr_en = 1'b0; wr_auto = 1'b0;
    check(wr_err === exp_err, req, {31'd0, wr_err}, {31'd0, exp_err});
  endtask

  task automatic rid_write(input logic [31:0] v, input logic [31:0] exp);
    @(negedge clk);
    rid_we = 1'b1; rid_wdata = v;
    @(negedge clk);
    rid_we = 1'b0;
    check(rid_q === exp, "R2 ring-identity write", rid_q, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rid_q === 32'h0403_0201, "R1 ring-identity reset", rid_q, 32'h0403_0201);
    check(rs_valid === 1'b0, "R1 no result after reset", {31'd0, rs_valid}, 32'd0);
    check(wr_err === 1'b0, "R1 no error after reset", {31'd0, wr_err}, 32'd0);
    look_bad(32'h0000_1000, 1'b1, 6'd24, "R1 R7 data miss after reset");
    look_bad(32'h0000_1000, 1'b0, 6'd16, "R1 R7 instruction miss after reset");

    // R4 R6: refill way entry, ASID from byte 1 (0x02 -> ring 1)
    write(1'b0, 3'd0, 32'h0000_3000, 32'h1234_5015, 1'b0, "R11 valid write no error");
    look_ok(32'h0000_3ABC, 1'b0, 2'd0, 3'd0, 3'd3, 2'd1, 32'h1234_5ABC, 4'h5, "R3 R4 R6 refill hit");
    look_ok(32'h0000_3ABC, 1'b1, 2'd1, 3'd0, 3'd3, 2'd1, 32'h1234_5ABC, 4'h5, "R3 data hit same ring");
    lookup(32'h0000_3ABC, 1'b0, 2'd2, 1'b1, 6'd18, 3'd0, 3'd3, 2'd1, 32'd0, 4'h5, "R9 instruction privilege");
    lookup(32'h0000_3ABC, 1'b1, 2'd3, 1'b1, 6'd26, 3'd0, 3'd3, 2'd1, 32'd0, 4'h5, "R9 data privilege");
    look_bad(32'h0000_2ABC, 1'b0, 6'd16, "R4 other index misses");
    look_bad(32'h0001_3ABC, 1'b1, 6'd24, "R4 tag mismatch misses");

    // R5: variable way, size 0 then size 1
    write(1'b0, 3'd4, 32'h0030_0000, 32'hABC0_0003, 1'b0, "R11 way4 write no error");
    look_ok(32'h0034_5678, 1'b1, 2'd0, 3'd4, 3'd3, 2'd0, 32'hABC4_5678, 4'h3, "R5 1MB page hit");
    look_bad(32'h0024_5678, 1'b1, 6'd24, "R5 1MB index miss");
    @(negedge clk); w4_size = 2'd1;
    write(1'b0, 3'd4, 32'h0080_0000, 32'h05C0_0031, 1'b0, "R11 way4 write no error");
    look_ok(32'h009A_BCDE, 1'b1, 2'd3, 3'd4, 3'd2, 2'd3, 32'h05DA_BCDE, 4'h1, "R5 4MB page hit");
    look_bad(32'h0034_5678, 1'b1, 6'd24, "R5 index moved with size");
    @(negedge clk); w4_size = 2'd0;

    // R8: multi-way hit
    write(1'b0, 3'd1, 32'h0000_3000, 32'h2222_2011, 1'b0, "R11 way1 write no error");
    look_bad(32'h0000_3000, 1'b0, 6'd17, "R8 instruction multi-hit");
    look_bad(32'h0000_3000, 1'b1, 6'd25, "R8 data multi-hit");

    // R2 R6: ring-identity changes
    rid_write(32'h0A0B_0C77, 32'h0A0B_0C01);
    look_bad(32'h0000_3000, 1'b1, 6'd24, "R6 unmatched ASID never hits");
    look_ok(32'h0034_5678, 1'b1, 2'd0, 3'd4, 3'd3, 2'd0, 32'hABC4_5678, 4'h3, "R6 ring0 ASID still hits");
    rid_write(32'h0302_0200, 32'h0302_0201);
    write(1'b0, 3'd3, 32'h0000_6000, 32'h7777_7022, 1'b0, "R11 way3 write no error");
    look_ok(32'h0000_6000, 1'b1, 2'd0, 3'd3, 3'd2, 2'd1, 32'h7777_7000, 4'h2, "R6 lowest matching ring");
    rid_write(32'h0000_0000, 32'h0000_0001);
    write(1'b0, 3'd2, 32'h0000_5000, 32'h4444_4031, 1'b0, "R11 way2 write no error");
    rid_write(32'h0403_0200, 32'h0403_0201);
    look_bad(32'h0000_5000, 1'b1, 6'd24, "R6 ASID zero never hits");

    // R10: round-robin placement
    write(1'b1, 3'd0, 32'h0000_7000, 32'h3333_3021, 1'b0, "R10 auto write no error");
    look_ok(32'h0000_7123, 1'b1, 2'd2, 3'd1, 3'd3, 2'd2, 32'h3333_3123, 4'h1, "R10 first auto to way1");
    look_ok(32'h0000_3000, 1'b0, 2'd0, 3'd0, 3'd3, 2'd1, 32'h1234_5000, 4'h5, "R8 multi-hit cleared");
    write(1'b1, 3'd0, 32'h0000_8000, 32'h3888_8001, 1'b0, "R10 auto write no error");
    look_ok(32'h0000_8004, 1'b1, 2'd0, 3'd2, 3'd0, 2'd0, 32'h3888_8004, 4'h1, "R10 second auto to way2");
    write(1'b1, 3'd0, 32'h0000_9000, 32'h3999_9001, 1'b0, "R10 auto write no error");
    look_ok(32'h0000_9FFF, 1'b1, 2'd0, 3'd3, 3'd1, 2'd0, 32'h3999_9FFF, 4'h1, "R10 third auto to way3");
    write(1'b1, 3'd0, 32'h0000_A000, 32'h3AAA_A001, 1'b0, "R10 auto write no error");
    look_ok(32'h0000_A010, 1'b1, 2'd0, 3'd0, 3'd2, 2'd0, 32'h3AAA_A010, 4'h1, "R10 fourth auto to way0");
    write(1'b1, 3'd0, 32'h0000_B000, 32'h3BBB_B001, 1'b0, "R10 auto write no error");
    look_ok(32'h0000_B000, 1'b1, 2'd0, 3'd1, 3'd3, 2'd0, 32'h3BBB_B000, 4'h1, "R10 wrap to way1");
    look_bad(32'h0000_7123, 1'b1, 6'd24, "R10 wrapped write replaced entry");

    // R11: rejected writes
    write(1'b0, 3'd5, 32'h0000_C000, 32'h3CCC_C001, 1'b1, "R11 way5 rejected");
    look_bad(32'h0000_C000, 1'b1, 6'd24, "R11 rejected write changed nothing");
    write(1'b0, 3'd7, 32'h0000_D000, 32'h3DDD_D001, 1'b1, "R11 way7 rejected");
    look_bad(32'h0000_D000, 1'b0, 6'd16, "R11 rejected write changed nothing");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R3 all results delivered", q.size(), 32'd0);
    finish_run();
  end
endmodule